// File: doc/BRIEF.md
# Smear-and-Increment Leading Zero Counter

This block counts the zero bits that stand above the most significant set bit of an operand, which is 32 bits wide by default. The count does not come from a priority encoder. It is built in three steps:

1. The highest set bit is spread downward into every lower position, so the word becomes a prefix of zeros followed by a run of ones.
2. One is added to that run, which leaves a single set bit in the position just above the run.
3. The position of that one-hot bit is turned into a binary count.

The adder is one bit wider than the operand, so that an operand with its top bit set can carry out.

The count ranges from 0 to WIDTH, so it needs one more bit than the log of WIDTH. With the default width the output is 6 bits. The datapath itself is purely combinational. To suit a pipelined FPGA design, the result is captured in an output register, so a count appears one clock after its operand.

A parameter selects how the increment step is built:

- a plain arithmetic adder, or
- an edge detector, which gives the same one-hot word for any smeared input without a carry chain.

Top module: `clz_smear_top`

## Requirements
- R1: The smear stage sets every bit at and below the highest set bit of the operand and clears every bit above it. As a result, two operands with the same highest set bit give the same count, whatever their lower bits hold.
- R2: Incrementing the smeared word gives a word of WIDTH+1 bits with exactly one bit set. That bit sits at position WIDTH minus the leading-zero count, so a single set bit at position k in the operand gives a count of WIDTH-1-k.
- R3: For any operand, count_o equals the number of consecutive zero bits counted from bit WIDTH-1 downward. This value appears on the first rising clock edge after the operand is applied, with rst low.
- R4: An all-zero operand gives a count of WIDTH (32 by default).
- R5: An operand with bit WIDTH-1 set gives a count of 0, including the all-ones operand whose increment carries into bit WIDTH.
- R6: While rst is high at a rising edge, count_o is cleared to 0 on that edge, whatever the operand holds.
- R7: count_o never exceeds WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| operand_i | input | WIDTH (32) | Word whose leading zeros are counted |
| count_o | output | $clog2(WIDTH+1) (6) | Registered leading-zero count, 0 to WIDTH |

## Verification
The hardest case to reach from the ports is the carry out of the top bit. It happens only when the smeared word is all ones, so it is not enough for the operand to have many bits set: bit WIDTH-1 must be set. The stimulus reaches it directly, with a lone top bit and with the all-ones word.

The opposite end, where the one-hot bit lands on bit 0, needs an exactly zero operand. The smear itself is probed by holding the highest set bit fixed while filling the lower bits with different patterns. This shows that only the leading one decides the count.

// File: rtl/clz_pkg.sv
package clz_pkg;
  localparam int CLZ_DEF_WIDTH = 32;

  typedef enum logic [0:0] {
    INC_ADDER = 1'b0,
    INC_EDGE  = 1'b1
  } inc_style_e;
endpackage

// File: rtl/clz_smear.sv
module clz_smear #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [WIDTH-1:0] run_o
);
  localparam int STAGES = $clog2(WIDTH);

  logic [WIDTH-1:0] lvl [0:STAGES];

  assign lvl[0] = vec_i;

  // each level doubles the reach of the ones spread below the top bit
  for (genvar k = 0; k < STAGES; k++) begin : g_lvl
    assign lvl[k+1] = lvl[k] | (lvl[k] >> (1 << k));
  end

  assign run_o = lvl[STAGES];
endmodule

// File: rtl/clz_inc.sv
module clz_inc
  import clz_pkg::*;
#(
  parameter int         WIDTH = 32,
  parameter inc_style_e STYLE = INC_ADDER
) (
  input  logic [WIDTH-1:0] run_i,
  output logic [WIDTH:0]   hot_o
);
  if (STYLE == INC_ADDER) begin : g_add
    // carry may leave the top operand bit, so the sum is one bit wider
    assign hot_o = {1'b0, run_i} + {{WIDTH{1'b0}}, 1'b1};
  end else begin : g_edge
    // for a zeros-then-ones word, +1 marks the first zero above the run
    assign hot_o = {run_i, 1'b1} & ~{1'b0, run_i};
  end
endmodule

// File: rtl/clz_encode.sv
module clz_encode #(
  parameter int WIDTH = 32,
  parameter int CW    = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH:0]  hot_i,
  output logic [CW-1:0]   cnt_o
);
  // each one-hot position drives the code of WIDTH minus that position,
  // so the subtraction folds into the OR tree
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i <= WIDTH; i++) begin
      if (hot_i[i]) cnt_o = cnt_o | CW'(WIDTH - i);
    end
  end
endmodule

// File: rtl/clz_smear_top.sv
module clz_smear_top
  import clz_pkg::*;
#(
  parameter int         WIDTH     = CLZ_DEF_WIDTH,
  parameter inc_style_e INC_STYLE = INC_ADDER,
  localparam int        CW        = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] operand_i,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] smear_w;
  logic [WIDTH:0]   onehot_w;
  logic [CW-1:0]    count_d;

  clz_smear #(.WIDTH(WIDTH)) u_smear (
    .vec_i (operand_i),
    .run_o (smear_w)
  );

  clz_inc #(.WIDTH(WIDTH), .STYLE(INC_STYLE)) u_inc (
    .run_i (smear_w),
    .hot_o (onehot_w)
  );

  clz_encode #(.WIDTH(WIDTH), .CW(CW)) u_enc (
    .hot_i (onehot_w),
    .cnt_o (count_d)
  );

  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else     count_o <= count_d;
  end

  // R1: smear result is a contiguous low run that covers every operand bit
  a_r1_smear_run: assert property (@(posedge clk) disable iff (rst)
    ((smear_w & (smear_w + 1'b1)) == '0) && ((smear_w | operand_i) == smear_w));

  // R2: increment leaves exactly one bit set
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(onehot_w));

  // R4: all-zero operand counts the full width
  a_r4_zero_full: assert property (@(posedge clk) disable iff (rst)
    (operand_i == '0) |=> (count_o == CW'(WIDTH)));

  // R5: top bit set gives zero count
  a_r5_msb_zero: assert property (@(posedge clk) disable iff (rst)
    operand_i[WIDTH-1] |=> (count_o == '0));

  // R6: reset clears the output register
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (count_o == '0));

  // R7: count stays in range
  a_r7_range: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(WIDTH));
endmodule

// File: tb/clz_smear_top_bench.sv
module clz_smear_top_bench;
  localparam int W  = 32;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  operand = '0;
  logic [CW-1:0] count;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  clz_smear_top u_clz_smear_top (
    .clk       (clk),
    .rst       (rst),
    .operand_i (operand),
    .count_o   (count)
  );

  function automatic int ref_clz(input logic [W-1:0] v);
    int n = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, sample at the next falling edge
  task automatic apply(input logic [W-1:0] v);
    @(negedge clk);
    operand = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    operand = 32'h0000_00F0;
    @(posedge clk);
    @(negedge clk);
    check("R6 reset clears count", int'(count), 0);
    rst = 1'b0;
  endtask

  task automatic t_single_bits();
    for (int k = 0; k < W; k++) begin
      apply(32'h1 << k);
      check("R2 single set bit", int'(count), W - 1 - k);
    end
  endtask

  task automatic t_zero();
    apply('0);
    check("R4 all zero", int'(count), W);
    check("R7 range at max", int'(count <= CW'(W)), 1);
  endtask

  task automatic t_top_bit();
    apply({W{1'b1}});
    check("R5 all ones carry out", int'(count), 0);
    apply(32'h8000_0000);
    check("R5 lone top bit", int'(count), 0);
    apply(32'hC000_0001);
    check("R5 top bit with others", int'(count), 0);
  endtask

  task automatic t_low_fill();
    logic [W-1:0] fills [4];
    fills[0] = 32'h0000_0000;
    fills[1] = 32'h0000_FFFF;
    fills[2] = 32'h0000_A5A5;
    fills[3] = 32'h0000_0001;
    for (int f = 0; f < 4; f++) begin
      apply(32'h0001_0000 | fills[f]);
      check("R1 lower bits ignored", int'(count), 15);
    end
  endtask

  task automatic t_random();
    logic [W-1:0] lfsr = 32'hACE1_1234;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      // vary the leading-one position by masking off a shifting top slice
      apply(lfsr >> (n % W));
      check("R3 random operand", int'(count), ref_clz(lfsr >> (n % W)));
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_single_bits();
    t_zero();
    t_top_bit();
    t_low_fill();
    t_random();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule